// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire SMBus

This block is an SMBus target that holds a small bank of 8-bit configuration registers for a clock generator. The register bits leave the block on one flat output, where they drive downstream controls such as the enable of each clock output buffer. A controller on the two-wire bus writes and reads these registers. It does so during system initialization only.

The block samples SCL and SDA with its own system clock. It finds start and stop conditions and compares the address byte against a fixed 7-bit address. It acknowledges bytes by pulling SDA low through an open-drain enable. The top bit of the command byte picks the access mode. In byte mode, a single register is addressed by the low command bits. In block mode, a count byte follows and the transfer starts at register zero and moves upward. Each byte is sent most significant bit first.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset, register i holds RST_VAL XOR i; with the defaults (RST_VAL = 0xFF, NUM_REGS = 8) this gives 0xFF, 0xFE, ... 0xF8. Register i occupies cfg_out[8*i+7 : 8*i].
- R2: The slave acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 0x69). That is 0xD2 for a write and 0xD3 for a read, with bit 0 as the read flag.
- R3: A non-matching address byte is not acknowledged. The slave then ignores the bus until the next start condition: it drives no SDA low and changes no register.
- R4: Byte write: a command byte with bit 7 = 1 gives the register offset in bits 6:0. The slave acknowledges the command and the next data byte, and stores that data byte at the offset.
- R5: Byte read: the controller sends the write address, a command with bit 7 = 1 and the offset, a repeated start and the read address. The slave then shifts out the register at that offset, MSB first.
- R6: Block write: a command byte with bit 7 = 0 is followed by a count byte. The data bytes after it go to registers 0, 1, 2, ... in that order.
- R7: A stop after any complete byte of a block write ends the transfer. Registers already written keep their new values, and later registers keep their old ones.
- R8: Block read: the controller sends the write address, command 0x00, a repeated start and the read address. The slave then returns a count byte equal to NUM_REGS, followed by registers 0, 1, 2, ... in order.
- R9: During a read, a NACK from the controller ends the data phase. The slave releases SDA and drives it no more until the next start condition.
- R10: A write to an offset at or above NUM_REGS is not acknowledged and changes no register.
- R11: The slave asserts its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| cfg_out | output | 8*NUM_REGS | Flat register contents, register i in bits 8*i+7:8*i |

## Verification
The hardest state to reach is the read path after a repeated start. There the pointer set by an earlier write phase must survive the new start. The count byte must come before the data, and a controller NACK must return the slave to silence. The bench drives a full write-then-read sequence with a bit-level bus model that resolves open-drain SDA as a wired-AND. It ends each read with a NACK and then clocks a further byte without a start, to show that the slave stays off the line.

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter int NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] RST_VAL = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] cfg_out
);
  localparam int PW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} st_t;
  st_t st;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr;
  logic       in_ack, nack, send_cnt;
  logic [7:0] regs [NUM_REGS];

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire in_range = ptr < 8'(NUM_REGS);
  wire byte_end = scl_fall & ~in_ack & (bitcnt == 4'd8) & ~start & ~stop;
  wire wr_fire  = byte_end & (st == S_WR) & in_range;
  wire st_idle  = (st == S_IDLE);
  wire [7:0] tx = send_cnt ? 8'(NUM_REGS) : (in_range ? regs[ptr[PW-1:0]] : 8'hFF);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign cfg_out[8*i +: 8] = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0;
      in_ack <= 1'b0; nack <= 1'b0; send_cnt <= 1'b0; sda_oe <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= RST_VAL ^ 8'(i);
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (start) begin
        st <= S_ADDR; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (in_ack) nack <= sda_s;
          else begin
            bitcnt <= bitcnt + 4'd1;
            if (st != S_RD) shreg <= {shreg[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (st == S_RD && !nack) sda_oe <= ~tx[7];
            else sda_oe <= 1'b0;
            if (st == S_RD && nack) st <= S_IDLE;
          end else if (bitcnt == 4'd8) begin
            in_ack <= 1'b1;
            case (st)
              S_ADDR: begin
                nack <= 1'b0;
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st <= shreg[0] ? S_RD : S_CMD;
                end else st <= S_IDLE;
              end
              S_CMD: begin
                sda_oe <= 1'b1;
                ptr <= shreg[7] ? {1'b0, shreg[6:0]} : 8'd0;
                send_cnt <= ~shreg[7];
                st <= shreg[7] ? S_WR : S_CNT;
              end
              S_CNT: begin
                sda_oe <= 1'b1;
                st <= S_WR;
              end
              S_WR: begin
                if (in_range) begin
                  sda_oe <= 1'b1;
                  regs[ptr[PW-1:0]] <= shreg;
                  ptr <= ptr + 8'd1;
                end
              end
              S_RD: begin
                sda_oe <= 1'b0;
                if (send_cnt) send_cnt <= 1'b0;
                else if (in_range) ptr <= ptr + 8'd1;
              end
              default: st <= S_IDLE;
            endcase
          end else if (st == S_RD) begin
            sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfg_smbus_chk.sv
module cfg_smbus_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  st_idle,
  input logic                  wr_fire,
  input logic [3:0]            bitcnt,
  input logic [8*NUM_REGS-1:0] cfg_out
);
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!scl_s));

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);

  assert_reg_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> $past(wr_fire));

  assert_bit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

bind cfg_smbus_slave cfg_smbus_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .st_idle(st_idle),
  .wr_fire(wr_fire), .bitcnt(bitcnt), .cfg_out(cfg_out)
);

// File: tb/sim_cfg_smbus_slave.sv
module sim_cfg_smbus_slave;
  localparam int N = 8;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic [8*N-1:0] cfg_out;
  wire sda_line = ~(m_low | sda_oe);

  int checks = 0, fails = 0, r11_viol = 0;
  logic [7:0] exp_r [N];

  always #4 clk = ~clk;

  cfg_smbus_slave u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
                      .sda_oe(sda_oe), .cfg_out(cfg_out));

  always @(posedge sda_oe) if (scl) r11_viol++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 1'b0; hq(); scl = 1'b1; hq(); m_low = 1'b1; hq(); scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hq(); scl = 1'b1; hq(); m_low = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
    end
    m_low = 1'b0; hq(); scl = 1'b1; hq(); ack = ~sda_line; hq(); scl = 1'b0; hq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl = 1'b1; hq(); b[i] = sda_line; hq(); scl = 1'b0; hq();
    end
    m_low = give_ack; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq(); m_low = 1'b0;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < N; i++) chk(req, cfg_out[8*i +: 8], exp_r[i]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) exp_r[i] = 8'hFF ^ 8'(i);
    check_regs("R1 reset default");
    chk("R1 sda released", sda_oe, 0);
  endtask

  task automatic t_byte_write();
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk("R2 write addr ack", a, 1);
    send_byte(8'h83, a); chk("R4 cmd ack", a, 1);
    send_byte(8'hA5, a); chk("R4 data ack", a, 1);
    bus_stop();
    exp_r[3] = 8'hA5;
    check_regs("R4 byte write");
  endtask

  task automatic t_byte_read();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h83, a);
    bus_start();
    send_byte(8'hD3, a); chk("R2 read addr ack", a, 1);
    recv_byte(1'b0, d); chk("R5 byte read data", d, 8'hA5);
    bus_stop();
  endtask

  task automatic t_block_write();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); chk("R6 block cmd ack", a, 1);
    send_byte(8'h03, a); chk("R6 count ack", a, 1);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk("R6 last data ack", a, 1);
    bus_stop();
    exp_r[0] = 8'h11; exp_r[1] = 8'h22; exp_r[2] = 8'h33;
    check_regs("R6 block write");
  endtask

  task automatic t_block_partial();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h04, a);
    send_byte(8'h44, a); send_byte(8'h55, a);
    bus_stop();
    exp_r[0] = 8'h44; exp_r[1] = 8'h55;
    check_regs("R7 early stop");
  endtask

  task automatic t_block_read();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, d); chk("R8 count byte", d, N);
    for (int i = 0; i < N; i++) begin
      recv_byte(i != N-1, d); chk("R8 block read data", d, exp_r[i]);
    end
    bus_stop();
  endtask

  task automatic t_nack_release();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h80, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, d); chk("R9 data before nack", d, exp_r[0]);
    chk("R9 released after nack", sda_oe, 0);
    send_byte(8'hD2, a); chk("R9 silent until start", a, 0);
    recv_byte(1'b0, d); chk("R9 no data driven", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R3 mismatch nack", a, 0);
    send_byte(8'h82, a); chk("R3 ignored cmd", a, 0);
    send_byte(8'h5A, a); chk("R3 ignored data", a, 0);
    bus_stop();
    check_regs("R3 regs untouched");
  endtask

  task automatic t_out_of_range();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h80 | 8'(N), a);
    send_byte(8'h77, a); chk("R10 out of range nack", a, 0);
    bus_stop();
    check_regs("R10 regs untouched");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_byte_read();
    t_block_write();
    t_block_partial();
    t_block_read();
    t_nack_release();
    t_bad_addr();
    t_out_of_range();
    chk("R11 pull-down only with SCL low", r11_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule